// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous, address-multiplexed DRAM alive. It waits out a power-up delay after reset and runs a fixed burst of CAS-before-RAS refresh cycles. Only then does it raise `ready`, the sign that the access path may start using the memory. From then on, every pulse of an external refresh tick adds one to a pending count. While that count is non-zero and no refresh cycle is running, the block raises a request to the access arbiter. When the arbiter acknowledges, the block runs one refresh cycle on the RAS#, CAS# and WE# strobes.

Every strobe interval is given in nanoseconds and converted to system-clock counts by rounding up, with a floor of one cycle. In each refresh cycle, CAS# falls first, RAS# follows, CAS# rises while RAS# is still low, and RAS# then rises. A precharge gap follows before another cycle may begin. WE# stays high throughout, so the memory never sees a test-mode entry. The `busy` output covers the whole cycle, precharge included, so the arbiter holds off normal accesses during that time. If the arbiter withholds the acknowledge long enough that the pending count would pass its depth, a sticky overflow flag is set.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, `ready`, `ref_req` and `overflow` are 0, and `busy` is 1.
- R2: After reset is released, the strobes stay high for exactly N_PWRUP = ceil(PWRUP_NS/CLK_PERIOD_NS) cycles. Then exactly INIT_CYCLES refresh cycles run back to back with no handshake. `ready` rises in the cycle the last precharge ends, and it stays at 1 until reset.
- R3: In every refresh cycle, `cas_n` is low for N_CSR cycles before `ras_n` falls. It stays low for N_CHR cycles after `ras_n` falls, and it rises while `ras_n` is still low.
- R4: `ras_n` stays low for max(N_RAS, N_CHR+1) cycles per refresh cycle. It stays high for N_PRE = max(N_RP, N_RPC) cycles after it rises, and only then may a new cycle begin.
- R5: `we_n` is 1 in every cycle.
- R6: A `refresh_tick` pulse adds one pending refresh only while `ready` is 1. Ticks before that have no effect, so `ref_req` stays 0 after `ready` rises unless a later tick arrives.
- R7: `ref_req` is 1 exactly when `ready` is 1, no refresh cycle is running and the pending count is non-zero. It stays 1 until it is acknowledged.
- R8: A clock edge that samples `ref_req` and `ref_ack` both at 1 starts a refresh cycle: `cas_n` is low in the very next cycle and the pending count drops by one. `ref_ack` has no effect while `ref_req` is 0.
- R9: `busy` is 1 from the cycle after a grant through the last precharge cycle, and during power-up and the initial burst. It is 0 otherwise.
- R10: The pending count saturates at PEND_DEPTH. A tick that arrives when the count is full and no grant is taken in the same cycle sets `overflow`, which then stays 1 until reset.
- R11: Every time limit in nanoseconds becomes ceil(ns/CLK_PERIOD_NS) cycles, with a minimum of one. At 10 ns this gives 1 cycle for CAS set-up, 1 cycle for CAS hold, 6 cycles of RAS low and 4 cycles of precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_tick | input | 1 | One-cycle pulse requesting one refresh |
| ref_ack | input | 1 | Arbiter grant for the pending request |
| ref_req | output | 1 | Refresh request to the arbiter |
| busy | output | 1 | A refresh or initialization cycle is in progress |
| ready | output | 1 | Initialization complete, normal access allowed |
| overflow | output | 1 | Sticky flag: a pending refresh was lost |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
All outputs are registered or decoded from registers, so each result is due exactly one clock after the edge that samples its cause. A grant makes `cas_n` low in the next cycle, and `ras_n` falls N_CSR cycles after that. The end of the last init precharge raises `ready` in the same cycle that `busy` falls, and a tick shows up as `ref_req` one cycle later. A behavioural reference model steps on every rising edge from the same inputs, and all outputs are compared with it at the falling edge. Inputs are changed just after the falling edge, so each check reads settled values. Directed measurements of strobe spacing, grant latency and the power-up length are taken in cycles and compared with the rounded-up constants.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_IDLE,
      ST_CAS,
      ST_BOTH,
      ST_RHOLD,
      ST_PRE
   } seq_state_t;

   // Round a nanosecond limit up to whole clock cycles, never below one.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
   parameter int unsigned W       = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_ref_pending.sv
module dram_ref_pending #(
   parameter int unsigned DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic nonzero,
   output logic overflow
);

   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] cnt_q;
   logic          ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         unique case ({inc, dec})
            2'b10: begin
               if (cnt_q == FULL) ovf_q <= 1'b1;
               else               cnt_q <= cnt_q + 1'b1;
            end
            2'b01: begin
               if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign nonzero  = (cnt_q != '0);
   assign overflow = ovf_q;

   AST_DEC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt_q != '0)); // R8
   AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL); // R10
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q); // R10

endmodule

// File: rtl/dram_ref_fsm.sv
module dram_ref_fsm
   import dram_ref_pkg::*;
#(
   parameter int unsigned N_PWRUP     = 20000,
   parameter int unsigned N_CSR       = 1,
   parameter int unsigned N_CHR       = 1,
   parameter int unsigned N_RAS       = 6,
   parameter int unsigned N_PRE       = 4,
   parameter int unsigned INIT_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic ready,
   output logic busy
);

   localparam int unsigned N_RHOLD = (N_RAS > N_CHR) ? (N_RAS - N_CHR) : 1;
   localparam int unsigned N_RASL  = N_CHR + N_RHOLD;
   localparam int unsigned MAXC    = umax(umax(N_PWRUP, N_PRE), umax(umax(N_CSR, N_CHR), N_RHOLD));
   localparam int unsigned TW      = $clog2(MAXC + 1);
   localparam int unsigned IW      = $clog2(INIT_CYCLES + 1);

   localparam logic [TW-1:0] V_CSR   = TW'(N_CSR - 1);
   localparam logic [TW-1:0] V_CHR   = TW'(N_CHR - 1);
   localparam logic [TW-1:0] V_RHOLD = TW'(N_RHOLD - 1);
   localparam logic [TW-1:0] V_PRE   = TW'(N_PRE - 1);

   seq_state_t    state_q, state_d;
   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic [IW-1:0] init_left_q;
   logic          ready_q;
   logic          ras_n_q, cas_n_q, we_n_q;
   logic          last_init;

   dram_ref_timer #(
      .W       (TW),
      .RST_VAL (N_PWRUP - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   assign last_init = (init_left_q <= IW'(1));

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_PWRUP: if (tmr_zero) begin
            state_d = ST_CAS;   tmr_load = 1'b1; tmr_val = V_CSR;
         end
         ST_IDLE: if (grant) begin
            state_d = ST_CAS;   tmr_load = 1'b1; tmr_val = V_CSR;
         end
         ST_CAS: if (tmr_zero) begin
            state_d = ST_BOTH;  tmr_load = 1'b1; tmr_val = V_CHR;
         end
         ST_BOTH: if (tmr_zero) begin
            state_d = ST_RHOLD; tmr_load = 1'b1; tmr_val = V_RHOLD;
         end
         ST_RHOLD: if (tmr_zero) begin
            state_d = ST_PRE;   tmr_load = 1'b1; tmr_val = V_PRE;
         end
         ST_PRE: if (tmr_zero) begin
            if (!ready_q && !last_init) begin
               state_d = ST_CAS; tmr_load = 1'b1; tmr_val = V_CSR;
            end else begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_PWRUP;
         init_left_q <= IW'(INIT_CYCLES);
         ready_q     <= 1'b0;
         ras_n_q     <= 1'b1;
         cas_n_q     <= 1'b1;
         we_n_q      <= 1'b1;
      end else begin
         state_q <= state_d;
         ras_n_q <= !(state_d == ST_BOTH || state_d == ST_RHOLD);
         cas_n_q <= !(state_d == ST_CAS  || state_d == ST_BOTH);
         we_n_q  <= 1'b1;
         if (state_q == ST_PRE && tmr_zero && !ready_q) begin
            if (last_init) ready_q <= 1'b1;
            else           init_left_q <= init_left_q - 1'b1;
         end
      end
   end

   assign ras_n = ras_n_q;
   assign cas_n = cas_n_q;
   assign we_n  = we_n_q;
   assign ready = ready_q;
   assign busy  = (state_q != ST_IDLE);

   // Run-length counters for the strobe-width checks.
   logic [31:0] ras_lo_len, ras_hi_len;
   logic        ras_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_lo_len <= '0;
         ras_hi_len <= '0;
         ras_seen_q <= 1'b0;
      end else begin
         ras_lo_len <= ras_n_q ? '0 : ras_lo_len + 1'b1;
         ras_hi_len <= ras_n_q ? ras_hi_len + 1'b1 : '0;
         if (!ras_n_q) ras_seen_q <= 1'b1;
      end
   end

   AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_q) |-> (!cas_n_q && $past(!cas_n_q))); // R3
   AST_CAS_RISE_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n_q) |-> !ras_n_q); // R3
   AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_q) |-> (ras_lo_len >= 32'(N_RASL))); // R4
   AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n_q) && ras_seen_q) |-> (ras_hi_len >= 32'(N_PRE))); // R4
   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> ready_q); // R2
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (ras_n_q && cas_n_q)); // R9

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_ref_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned PWRUP_NS      = 200000,
   parameter int unsigned INIT_CYCLES   = 8,
   parameter int unsigned PEND_DEPTH    = 8,
   parameter int unsigned T_CSR_NS      = 5,
   parameter int unsigned T_CHR_NS      = 10,
   parameter int unsigned T_RAS_NS      = 60,
   parameter int unsigned T_RP_NS       = 40,
   parameter int unsigned T_RPC_NS      = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refresh_tick,
   input  logic ref_ack,
   output logic ref_req,
   output logic busy,
   output logic ready,
   output logic overflow,
   output logic ras_n,
   output logic cas_n,
   output logic we_n
);

   localparam int unsigned N_PWRUP = ns_to_cyc(PWRUP_NS, CLK_PERIOD_NS);
   localparam int unsigned N_CSR   = ns_to_cyc(T_CSR_NS, CLK_PERIOD_NS);
   localparam int unsigned N_CHR   = ns_to_cyc(T_CHR_NS, CLK_PERIOD_NS);
   localparam int unsigned N_RAS   = ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS);
   localparam int unsigned N_PRE   = umax(ns_to_cyc(T_RP_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_RPC_NS, CLK_PERIOD_NS));

   initial begin
      assert (CLK_PERIOD_NS > 0) else $error("CLK_PERIOD_NS must be non-zero");
      assert (INIT_CYCLES > 0)   else $error("INIT_CYCLES must be non-zero");
      assert (PEND_DEPTH > 0)    else $error("PEND_DEPTH must be non-zero");
   end

   logic busy_w, ready_w, pend_nz, grant;

   dram_ref_fsm #(
      .N_PWRUP     (N_PWRUP),
      .N_CSR       (N_CSR),
      .N_CHR       (N_CHR),
      .N_RAS       (N_RAS),
      .N_PRE       (N_PRE),
      .INIT_CYCLES (INIT_CYCLES)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .grant (grant),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .ready (ready_w),
      .busy  (busy_w)
   );

   dram_ref_pending #(
      .DEPTH (PEND_DEPTH)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (refresh_tick & ready_w),
      .dec      (grant),
      .nonzero  (pend_nz),
      .overflow (overflow)
   );

   assign ref_req = ready_w & ~busy_w & pend_nz;
   assign grant   = ref_req & ref_ack;
   assign busy    = busy_w;
   assign ready   = ready_w;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_ack) |=> ref_req); // R7
   AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> (!cas_n && ras_n && busy)); // R8
   AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !ref_req); // R6
   AST_WE_HIGH_AT_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (we_n && $past(we_n))); // R5

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;

   localparam int PER    = 10;
   localparam int PW_NS  = 1000;
   localparam int INIT   = 8;
   localparam int DEPTH  = 8;

   // Expected cycle counts, rounded up from the nanosecond limits (R11)
   localparam int NPW  = (PW_NS + PER - 1) / PER;
   localparam int CSR  = 1;
   localparam int CHR  = 1;
   localparam int RASL = 6;
   localparam int PRE  = 4;
   localparam int LEN  = CSR + RASL + PRE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic refresh_tick = 1'b0;
   logic ref_ack = 1'b0;
   logic ref_req, busy, ready, overflow, ras_n, cas_n, we_n;

   always #5 clk = ~clk;

   dram_refresh_seq #(
      .CLK_PERIOD_NS (PER),
      .PWRUP_NS      (PW_NS),
      .INIT_CYCLES   (INIT),
      .PEND_DEPTH    (DEPTH)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .refresh_tick (refresh_tick),
      .ref_ack      (ref_ack),
      .ref_req      (ref_req),
      .busy         (busy),
      .ready        (ready),
      .overflow     (overflow),
      .ras_n        (ras_n),
      .cas_n        (cas_n),
      .we_n         (we_n)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   // Behavioural reference model
   int m_pw = NPW;
   int m_pos = -1;
   int m_init = 0;
   int m_pend = 0;
   bit m_ready = 0;
   bit m_ovf = 0;

   function automatic bit e_req();
      return m_ready && m_pos < 0 && m_pend > 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pw = NPW; m_pos = -1; m_init = 0; m_pend = 0; m_ready = 0; m_ovf = 0;
      end else begin
         bit g, rdy_old;
         g = e_req() && ref_ack;
         rdy_old = m_ready;
         if (m_pw > 0) begin
            if (m_pw == 1) begin m_pw = 0; m_pos = 0; m_init = INIT; end
            else m_pw--;
         end else if (m_pos >= 0) begin
            if (m_pos == LEN - 1) begin
               if (!m_ready) begin
                  if (m_init > 1) begin m_init--; m_pos = 0; end
                  else begin m_ready = 1; m_pos = -1; end
               end else m_pos = -1;
            end else m_pos++;
         end else if (g) m_pos = 0;
         if (rdy_old && refresh_tick && !g) begin
            if (m_pend == DEPTH) m_ovf = 1; else m_pend++;
         end else if (g && !(rdy_old && refresh_tick)) m_pend--;
      end
   end

   // Per-cycle comparison and strobe measurements
   int t = 0;
   int first_cas_t = -1, cas_fall_t = 0, ras_fall_t = 0;
   int csr_meas = 0, chr_meas = 0, ras_w = 0, falls_pre_ready = 0;
   logic p_ras = 1'b1, p_cas = 1'b1;

   always @(negedge clk) begin
      if (rst_n) t++;
      chk("R4 ras_n", ras_n, !(m_pos >= CSR && m_pos < CSR + RASL));
      chk("R3 cas_n", cas_n, !(m_pos >= 0 && m_pos < CSR + CHR));
      chk("R5 we_n", we_n, 1);
      chk("R2 ready", ready, m_ready);
      chk("R7 ref_req", ref_req, e_req());
      chk("R9 busy", busy, (m_pw > 0) || (m_pos >= 0));
      chk("R10 overflow", overflow, m_ovf);
      if (p_cas && !cas_n) begin
         cas_fall_t = t;
         if (first_cas_t < 0) first_cas_t = t;
      end
      if (p_ras && !ras_n) begin
         csr_meas = t - cas_fall_t; ras_fall_t = t;
         if (!ready) falls_pre_ready++;
      end
      if (!p_cas && cas_n) chr_meas = t - ras_fall_t;
      if (!p_ras && ras_n) ras_w = t - ras_fall_t;
      p_ras = ras_n; p_cas = cas_n;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL R2 watchdog actual=%0d expected<=20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      int ack_t;
      step(4);
      // R1: reset values
      chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1); chk("R1 we_n", we_n, 1);
      chk("R1 ready", ready, 0); chk("R1 ref_req", ref_req, 0);
      chk("R1 overflow", overflow, 0); chk("R1 busy", busy, 1);
      rst_n = 1'b1;
      // R6: ticks and acks before ready are ignored
      step(10);
      refresh_tick = 1'b1; ref_ack = 1'b1;
      step(3);
      refresh_tick = 1'b0; ref_ack = 1'b0;
      while (!ready) step(1);
      chk("R2 powerup length", first_cas_t, NPW);
      chk("R2 init burst count", falls_pre_ready, INIT);
      chk("R2 ready time", t, NPW + INIT * LEN);
      step(5);
      chk("R6 no request from early ticks", ref_req, 0);
      // R8: ack with nothing pending is ignored
      ref_ack = 1'b1; step(3); ref_ack = 1'b0;
      chk("R8 ack ignored", ras_n, 1);
      // R7: request held until ack
      refresh_tick = 1'b1; step(1); refresh_tick = 1'b0;
      step(10);
      chk("R7 request held", ref_req, 1);
      ack_t = t; ref_ack = 1'b1; step(1); ref_ack = 1'b0;
      chk("R8 grant latency", cas_fall_t, ack_t + 1);
      step(LEN + 2);
      chk("R11 cas setup cycles", csr_meas, CSR);
      chk("R3 cas hold cycles", chr_meas, CHR);
      chk("R4 ras low cycles", ras_w, RASL);
      chk("R8 pending drained", ref_req, 0);
      // ticks during a running refresh are counted
      refresh_tick = 1'b1; step(1); refresh_tick = 1'b0;
      ref_ack = 1'b1; step(3); ref_ack = 1'b0;
      refresh_tick = 1'b1; step(2); refresh_tick = 1'b0;
      step(LEN);
      chk("R6 ticks during refresh", ref_req, 1);
      ref_ack = 1'b1; step(3 * LEN); ref_ack = 1'b0;
      chk("R8 queue empty", ref_req, 0);
      // R10: flood the queue to overflow
      refresh_tick = 1'b1; step(DEPTH + 4); refresh_tick = 1'b0;
      chk("R10 overflow set", overflow, 1);
      // drain with ack held, plus a tick coinciding with ack
      ref_ack = 1'b1; step(2 * LEN);
      refresh_tick = 1'b1; step(1); refresh_tick = 1'b0;
      step((DEPTH + 2) * (LEN + 1));
      ref_ack = 1'b0; step(2);
      chk("R10 overflow sticky", overflow, 1);
      chk("R7 all serviced", ref_req, 0);
      chk("R9 idle at end", busy, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule